// File: doc/BRIEF.md
# Master-Slave Mailbox with Wait Handshake

This block is the byte-wide gateway between a bus master and one slave processor. The master reaches it through four consecutive ports: status and control, data, flag clear and one unused port. The slot's position among neighbouring slots is fixed by a parameter. The high nibble of the slot address comes from four active-low configuration straps. The slave reaches it through 16-address I/O pages. On the slave side, a plain read of some pages sets or clears a flag, one page returns the message bits, and one page is the data port.

An access by the slave to its data page stalls the slave: `s_wait` stays high until the master performs the opposite transfer on its data port. A slave write is latched for the master to read. A slave read is satisfied by the byte the master writes. The block also holds the slave in reset until the master releases it. A master data access that has no matching stalled slave transfer is refused and recorded in an error flag.

Top module: `mslv_mailbox`

## Requirements
- R1: The master side is selected when `m_addr[7:4]` equals the bitwise inverse of `base_jmp_n` (an open strap reads 1) and `m_addr[3:2]` equals `SLOT_IDX`. `m_addr[1:0]` selects offset 0 control/status, 1 data, 2 clear or 3 unused. While the master side is not selected, `m_rdata` is 0xFF and writes change nothing.
- R2: A master write at offset 0 holds the slave in reset when bit 4 = 1 and releases it when bit 4 = 0 (`s_reset_n` low while held). Bit 1 = 1 sets MASTER MESSAGE, and bit 1 = 0 leaves it unchanged.
- R3: After `rst_n`, the slave is held in reset, the MASTER MESSAGE, SLAVE MESSAGE and ALIVE flags are clear, `s_wait` is low and `proto_err` is low.
- R4: A master read at offset 0 returns: bit 0 MASTER MESSAGE, bit 1 SLAVE MESSAGE, bit 2 ALIVE (active low), bit 3 HOLD (active low), bit 4 direction (1 = slave reading, 0 = slave writing, keeps its last value while idle), bit 5 RESET (active low), and bits 7:6 = 11. The value after reset is 0xCC.
- R5: A slave read strobe on page 0x2 sets SLAVE MESSAGE, on page 0x3 clears MASTER MESSAGE, and on page 0x6 sets ALIVE. With page 0x5 selected, `s_rdata` shows bit 0 MASTER MESSAGE and bit 1 SLAVE MESSAGE, with the other bits 0.
- R6: A master read at offset 2 clears ALIVE. A master write at offset 2 clears SLAVE MESSAGE.
- R7: A slave write on page 0x7 latches `s_wdata`, raises `s_wait` and sets direction 0. `s_wait` stays high until a master read at offset 1, which returns the latched byte. `s_wait` is low from the next cycle.
- R8: A slave read on page 0x7 raises `s_wait` and sets direction 1. A master write at offset 1 releases it, and from the next cycle `s_rdata` shows that byte while page 0x7 is selected.
- R9: A master data access with no stalled slave transfer of the opposite direction is ignored: a read returns 0xFF, `s_wait` is unchanged, and `proto_err` rises and stays high until `rst_n`.
- R10: While the slave is held in reset, ALIVE, SLAVE MESSAGE and HOLD are clear and slave strobes have no effect. MASTER MESSAGE keeps its value.
- R11: When a set and a clear of the same flag arrive in one cycle, the set wins. This covers a slave page 0x2 read together with a master offset 2 write, and a master control write with bit 1 = 1 together with a slave page 0x3 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_jmp_n | input | 4 | Active-low base-nibble straps |
| m_addr | input | 8 | Master I/O address |
| m_rd | input | 1 | Master read strobe, one cycle |
| m_wr | input | 1 | Master write strobe, one cycle |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data |
| m_sel | output | 1 | Master address hits this slot |
| s_io_page | input | 4 | Upper nibble of the slave I/O address |
| s_rd | input | 1 | Slave read strobe, one cycle |
| s_wr | input | 1 | Slave write strobe, one cycle |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data |
| s_wait | output | 1 | Stall to the slave processor |
| s_reset_n | output | 1 | Reset to the slave processor, active low |
| proto_err | output | 1 | Master data access without a matching stall |

## Verification
Two sides of the block can act on one flag in the same cycle. The slave may set SLAVE MESSAGE while the master clears it, or the master may set MASTER MESSAGE while the slave clears it. The bench provokes each case by raising both strobes in the same clock window. It judges the result by reading the master status port, which must show the flag set. A further collision is a master reset command arriving while the slave is stalled. There the bench expects `s_wait` and the slave-side flags to drop together with `s_reset_n`.

// File: rtl/mslv_pkg.sv
package mslv_pkg;
   typedef enum logic [1:0] {
      OFS_CTRL = 2'd0,
      OFS_DATA = 2'd1,
      OFS_CLR  = 2'd2,
      OFS_NONE = 2'd3
   } mofs_e;

   localparam int ST_MMSG    = 0;
   localparam int ST_SMSG    = 1;
   localparam int ST_ALIVE_N = 2;
   localparam int ST_HOLD_N  = 3;
   localparam int ST_DIR     = 4;
   localparam int ST_RST_N   = 5;

   localparam int CTL_MMSG   = 1;
   localparam int CTL_RST    = 4;

   localparam int PG_SMSG_SET  = 2;
   localparam int PG_MMSG_CLR  = 3;
   localparam int PG_STAT      = 5;
   localparam int PG_ALIVE_SET = 6;
   localparam int PG_DATA      = 7;
endpackage

// File: rtl/mslv_mdec.sv
module mslv_mdec
   import mslv_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BASE_W   = 4,
   parameter int SLOT_W   = 2,
   parameter int SLOT_IDX = 1
) (
   input  logic [BASE_W-1:0] base_jmp_n,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic              m_rd,
   input  logic              m_wr,
   output logic              sel,
   output logic              ctl_wr,
   output logic              stat_rd,
   output logic              data_rd,
   output logic              data_wr,
   output logic              alive_clr,
   output logic              smsg_clr
);
   localparam int OFS_W = ADDR_W - BASE_W - SLOT_W;

   generate
      if (OFS_W != 2) begin : g_bad_split
         $error("mslv_mdec: address split must leave two offset bits");
      end
      if (SLOT_IDX >= (1 << SLOT_W)) begin : g_bad_slot
         $error("mslv_mdec: SLOT_IDX does not fit SLOT_W");
      end
   endgenerate

   logic  base_hit, slot_hit;
   mofs_e ofs;

   assign base_hit = (m_addr[ADDR_W-1 -: BASE_W] == ~base_jmp_n);
   assign slot_hit = (m_addr[OFS_W +: SLOT_W] == SLOT_W'(SLOT_IDX));
   assign ofs      = mofs_e'(m_addr[1:0]);
   assign sel      = base_hit & slot_hit;

   assign ctl_wr    = sel & m_wr & (ofs == OFS_CTRL);
   assign stat_rd   = sel & m_rd & (ofs == OFS_CTRL);
   assign data_rd   = sel & m_rd & (ofs == OFS_DATA);
   assign data_wr   = sel & m_wr & (ofs == OFS_DATA);
   assign alive_clr = sel & m_rd & (ofs == OFS_CLR);
   assign smsg_clr  = sel & m_wr & (ofs == OFS_CLR);
endmodule

// File: rtl/mslv_sdec.sv
module mslv_sdec
   import mslv_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic [PAGE_W-1:0] page,
   input  logic              s_rd,
   input  logic              s_wr,
   input  logic              en,
   output logic              smsg_set,
   output logic              mmsg_clr,
   output logic              alive_set,
   output logic              stat_pg,
   output logic              data_pg,
   output logic              data_get,
   output logic              data_put
);
   generate
      if (PAGE_W < 3) begin : g_bad_page
         $error("mslv_sdec: PAGE_W too small for the page map");
      end
   endgenerate

   function automatic logic pg_is(input logic [PAGE_W-1:0] p, input int code);
      return p == PAGE_W'(code);
   endfunction

   assign stat_pg   = en & pg_is(page, PG_STAT);
   assign data_pg   = en & pg_is(page, PG_DATA);
   assign smsg_set  = en & s_rd & pg_is(page, PG_SMSG_SET);
   assign mmsg_clr  = en & s_rd & pg_is(page, PG_MMSG_CLR);
   assign alive_set = en & s_rd & pg_is(page, PG_ALIVE_SET);
   assign data_get  = data_pg & s_rd;
   assign data_put  = data_pg & s_wr;
endmodule

// File: rtl/mslv_flags.sv
module mslv_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_rst_bit,
   input  logic ctl_mmsg_bit,
   input  logic smsg_set,
   input  logic smsg_clr,
   input  logic mmsg_clr,
   input  logic alive_set,
   input  logic alive_clr,
   output logic mmsg,
   output logic smsg,
   output logic alive,
   output logic slv_rst,
   output logic slv_clr
);
   logic mmsg_q, smsg_q, alive_q, rst_q;
   logic rst_go;

   assign rst_go  = ctl_wr & ctl_rst_bit;
   assign slv_clr = rst_q | rst_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q   <= 1'b1;
         mmsg_q  <= 1'b0;
         smsg_q  <= 1'b0;
         alive_q <= 1'b0;
      end else begin
         if (ctl_wr) rst_q <= ctl_rst_bit;

         if (ctl_wr && ctl_mmsg_bit) mmsg_q <= 1'b1;
         else if (mmsg_clr)          mmsg_q <= 1'b0;

         if (slv_clr)       smsg_q <= 1'b0;
         else if (smsg_set) smsg_q <= 1'b1;
         else if (smsg_clr) smsg_q <= 1'b0;

         if (slv_clr)        alive_q <= 1'b0;
         else if (alive_set) alive_q <= 1'b1;
         else if (alive_clr) alive_q <= 1'b0;
      end
   end

   assign mmsg    = mmsg_q;
   assign smsg    = smsg_q;
   assign alive   = alive_q;
   assign slv_rst = rst_q;
endmodule

// File: rtl/mslv_hold.sv
module mslv_hold #(
   parameter int DATA_W     = 8,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              s_get,
   input  logic              s_put,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              m_take,
   input  logic              m_give,
   input  logic [DATA_W-1:0] m_wdata,
   output logic              hold,
   output logic              dir,
   output logic              done,
   output logic [DATA_W-1:0] to_master,
   output logic [DATA_W-1:0] to_slave,
   output logic              perr
);
   logic hold_q, dir_q, misuse;
   logic [DATA_W-1:0] tom_q, tos_q;

   assign done   = hold_q & ((m_take & ~dir_q) | (m_give & dir_q));
   assign misuse = (m_take | m_give) & ~done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         dir_q  <= 1'b0;
         tom_q  <= '0;
         tos_q  <= '0;
      end else begin
         if (clr)       hold_q <= 1'b0;
         else if (done) hold_q <= 1'b0;
         else if (!hold_q && (s_get || s_put)) begin
            hold_q <= 1'b1;
            dir_q  <= s_get;
         end
         if (!clr && !hold_q && s_put) tom_q <= s_wdata;
         if (done && dir_q)            tos_q <= m_wdata;
      end
   end

   generate
      if (ERR_STICKY) begin : g_sticky
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      err_q <= 1'b0;
            else if (misuse) err_q <= 1'b1;
         end
         assign perr = err_q;
      end else begin : g_pulse
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= misuse;
         end
         assign perr = err_q;
      end
   endgenerate

   assign hold      = hold_q;
   assign dir       = dir_q;
   assign to_master = tom_q;
   assign to_slave  = tos_q;
endmodule

// File: rtl/mslv_mailbox.sv
module mslv_mailbox
   import mslv_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int BASE_W     = 4,
   parameter int SLOT_W     = 2,
   parameter int SLOT_IDX   = 1,
   parameter int PAGE_W     = 4,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] base_jmp_n,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic              m_rd,
   input  logic              m_wr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   output logic              m_sel,
   input  logic [PAGE_W-1:0] s_io_page,
   input  logic              s_rd,
   input  logic              s_wr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              s_wait,
   output logic              s_reset_n,
   output logic              proto_err
);
   localparam int ST_BITS = ST_RST_N + 1;

   generate
      if (DATA_W < ST_BITS) begin : g_bad_width
         $error("mslv_mailbox: DATA_W too narrow for the status byte");
      end
   endgenerate

   logic ctl_wr_w, stat_rd_w, data_rd_w, data_wr_w, alive_clr_w, smsg_clr_w;
   logic smsg_set_w, mmsg_clr_w, alive_set_w, stat_pg_w, data_pg_w;
   logic data_get_w, data_put_w;
   logic mmsg_w, smsg_w, alive_w, slv_rst_w, slv_clr_w;
   logic hold_w, dir_w, done_w;
   logic [DATA_W-1:0] tom_w, tos_w, status_w, sstat_w;

   mslv_mdec #(
      .ADDR_W(ADDR_W), .BASE_W(BASE_W), .SLOT_W(SLOT_W), .SLOT_IDX(SLOT_IDX)
   ) u_mdec (
      .base_jmp_n(base_jmp_n), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
      .sel(m_sel), .ctl_wr(ctl_wr_w), .stat_rd(stat_rd_w),
      .data_rd(data_rd_w), .data_wr(data_wr_w),
      .alive_clr(alive_clr_w), .smsg_clr(smsg_clr_w)
   );

   mslv_sdec #(.PAGE_W(PAGE_W)) u_sdec (
      .page(s_io_page), .s_rd(s_rd), .s_wr(s_wr), .en(~slv_rst_w),
      .smsg_set(smsg_set_w), .mmsg_clr(mmsg_clr_w), .alive_set(alive_set_w),
      .stat_pg(stat_pg_w), .data_pg(data_pg_w),
      .data_get(data_get_w), .data_put(data_put_w)
   );

   mslv_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr_w), .ctl_rst_bit(m_wdata[CTL_RST]), .ctl_mmsg_bit(m_wdata[CTL_MMSG]),
      .smsg_set(smsg_set_w), .smsg_clr(smsg_clr_w), .mmsg_clr(mmsg_clr_w),
      .alive_set(alive_set_w), .alive_clr(alive_clr_w),
      .mmsg(mmsg_w), .smsg(smsg_w), .alive(alive_w),
      .slv_rst(slv_rst_w), .slv_clr(slv_clr_w)
   );

   mslv_hold #(.DATA_W(DATA_W), .ERR_STICKY(ERR_STICKY)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(slv_clr_w),
      .s_get(data_get_w), .s_put(data_put_w), .s_wdata(s_wdata),
      .m_take(data_rd_w), .m_give(data_wr_w), .m_wdata(m_wdata),
      .hold(hold_w), .dir(dir_w), .done(done_w),
      .to_master(tom_w), .to_slave(tos_w), .perr(proto_err)
   );

   always_comb begin
      status_w             = '1;
      status_w[ST_MMSG]    = mmsg_w;
      status_w[ST_SMSG]    = smsg_w;
      status_w[ST_ALIVE_N] = ~alive_w;
      status_w[ST_HOLD_N]  = ~hold_w;
      status_w[ST_DIR]     = dir_w;
      status_w[ST_RST_N]   = ~slv_rst_w;
   end

   always_comb begin
      sstat_w          = '0;
      sstat_w[ST_MMSG] = mmsg_w;
      sstat_w[ST_SMSG] = smsg_w;
   end

   always_comb begin
      if (stat_rd_w)                m_rdata = status_w;
      else if (data_rd_w && done_w) m_rdata = tom_w;
      else                          m_rdata = '1;
   end

   always_comb begin
      if (stat_pg_w)      s_rdata = sstat_w;
      else if (data_pg_w) s_rdata = tos_w;
      else                s_rdata = '1;
   end

   assign s_wait    = hold_w;
   assign s_reset_n = ~slv_rst_w;
endmodule

// File: rtl/mslv_mailbox_chk.sv
module mslv_mailbox_chk #(
   parameter int DATA_W     = 8,
   parameter bit ERR_STICKY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_sel,
   input logic              m_rd,
   input logic [1:0]        m_ofs,
   input logic [DATA_W-1:0] m_rdata,
   input logic              s_wait,
   input logic              s_reset_n,
   input logic              proto_err,
   input logic              ctl_wr,
   input logic              done
);
   assert_unsel_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !m_sel |-> (m_rdata == {DATA_W{1'b1}}));

   assert_reset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_reset_n && !ctl_wr) |=> !s_reset_n);

   assert_pad_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_sel && m_rd && m_ofs == 2'd0) |-> (m_rdata[DATA_W-1 -: 2] == 2'b11));

   assert_wait_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wait && !done && s_reset_n && !ctl_wr) |=> s_wait);

   assert_wait_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !s_wait);

   assert_no_wait_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !s_reset_n |-> !s_wait);

   generate
      if (ERR_STICKY) begin : g_sticky_chk
         assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            proto_err |=> proto_err);
      end
   endgenerate
endmodule

bind mslv_mailbox mslv_mailbox_chk #(.DATA_W(DATA_W), .ERR_STICKY(ERR_STICKY)) u_chk (
   .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_rd(m_rd), .m_ofs(m_addr[1:0]),
   .m_rdata(m_rdata), .s_wait(s_wait), .s_reset_n(s_reset_n), .proto_err(proto_err),
   .ctl_wr(ctl_wr_w), .done(done_w)
);

// File: tb/mslv_mailbox_test.sv
`timescale 1ns/1ps
module mslv_mailbox_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] base_jmp_n = 4'b0110;   // base nibble 9, slot 1 -> 0x94..0x97
   logic [7:0] m_addr = 8'h00;
   logic       m_rd = 1'b0, m_wr = 1'b0;
   logic [7:0] m_wdata = 8'h00;
   logic [7:0] m_rdata;
   logic       m_sel;
   logic [3:0] s_io_page = 4'h0;
   logic       s_rd = 1'b0, s_wr = 1'b0;
   logic [7:0] s_wdata = 8'h00;
   logic [7:0] s_rdata;
   logic       s_wait, s_reset_n, proto_err;

   int total = 0;
   int bad = 0;

   localparam logic [7:0] M_CTL = 8'h94, M_DAT = 8'h95, M_CLR = 8'h96;

   always #4 clk = ~clk;

   mslv_mailbox uut (
      .clk(clk), .rst_n(rst_n), .base_jmp_n(base_jmp_n),
      .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_sel(m_sel),
      .s_io_page(s_io_page), .s_rd(s_rd), .s_wr(s_wr), .s_wdata(s_wdata),
      .s_rdata(s_rdata), .s_wait(s_wait), .s_reset_n(s_reset_n), .proto_err(proto_err)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic m_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); m_addr = a; m_wdata = d; m_wr = 1'b1;
      @(negedge clk); m_wr = 1'b0;
   endtask

   task automatic m_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); m_addr = a; m_rd = 1'b1;
      #1 d = m_rdata;
      @(negedge clk); m_rd = 1'b0;
   endtask

   task automatic s_read(input logic [3:0] p);
      @(negedge clk); s_io_page = p; s_rd = 1'b1;
      @(negedge clk); s_rd = 1'b0;
   endtask

   task automatic s_write(input logic [3:0] p, input logic [7:0] d);
      @(negedge clk); s_io_page = p; s_wdata = d; s_wr = 1'b1;
      @(negedge clk); s_wr = 1'b0;
   endtask

   task automatic stat_is(input string req, input logic [7:0] exp);
      logic [7:0] v;
      m_read(M_CTL, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      chk("R3 s_reset_n", {7'd0, s_reset_n}, 8'd0);
      chk("R3 s_wait", {7'd0, s_wait}, 8'd0);
      chk("R3 proto_err", {7'd0, proto_err}, 8'd0);
      stat_is("R3/R4 reset status", 8'hCC);
   endtask

   task automatic t_decode;
      logic [7:0] v;
      m_read(8'h90, v);
      chk("R1 other slot read", v, 8'hFF);
      m_read(8'hA4, v);
      chk("R1 other base read", v, 8'hFF);
      m_write(8'h90, 8'h00);
      m_write(8'h14, 8'h00);
      chk("R1 unselected write keeps reset", {7'd0, s_reset_n}, 8'd0);
   endtask

   task automatic t_control;
      m_write(M_CTL, 8'h00);
      chk("R2 release", {7'd0, s_reset_n}, 8'd1);
      stat_is("R2/R4 released status", 8'hEC);
      m_write(M_CTL, 8'h02);
      stat_is("R2 master message set", 8'hED);
      m_write(M_CTL, 8'h00);
      stat_is("R2 bit1=0 keeps message", 8'hED);
   endtask

   task automatic t_slave_flags;
      @(negedge clk); s_io_page = 4'h5;
      #1 chk("R5 slave status page", s_rdata, 8'h01);
      s_read(4'h2);
      s_read(4'h6);
      stat_is("R5 slave message and alive set", 8'hEB);
      s_read(4'h3);
      stat_is("R5 master message cleared", 8'hEA);
      @(negedge clk); s_io_page = 4'h5;
      #1 chk("R5 slave status after clear", s_rdata, 8'h02);
   endtask

   task automatic t_master_clear;
      logic [7:0] v;
      m_read(M_CLR, v);
      stat_is("R6 alive cleared by read", 8'hEE);
      m_write(M_CLR, 8'h00);
      stat_is("R6 slave message cleared by write", 8'hEC);
   endtask

   task automatic t_slave_write;
      logic [7:0] v;
      s_write(4'h7, 8'hA5);
      chk("R7 wait raised", {7'd0, s_wait}, 8'd1);
      stat_is("R7 status writing in hold", 8'hE4);
      repeat (5) @(negedge clk);
      chk("R7 wait held", {7'd0, s_wait}, 8'd1);
      m_read(M_DAT, v);
      chk("R7 master gets byte", v, 8'hA5);
      chk("R7 wait released", {7'd0, s_wait}, 8'd0);
      chk("R7 no error", {7'd0, proto_err}, 8'd0);
   endtask

   task automatic t_slave_read;
      s_read(4'h7);
      chk("R8 wait raised", {7'd0, s_wait}, 8'd1);
      stat_is("R8 status reading in hold", 8'hF4);
      m_write(M_DAT, 8'h3C);
      chk("R8 wait released", {7'd0, s_wait}, 8'd0);
      @(negedge clk); s_io_page = 4'h7;
      #1 chk("R8 slave gets byte", s_rdata, 8'h3C);
      stat_is("R8 direction kept while idle", 8'hFC);
   endtask

   task automatic t_protocol;
      logic [7:0] v;
      m_read(M_DAT, v);
      chk("R9 idle data read", v, 8'hFF);
      chk("R9 error raised", {7'd0, proto_err}, 8'd1);
      s_write(4'h7, 8'h5A);
      m_write(M_DAT, 8'h77);
      chk("R9 wrong direction ignored", {7'd0, s_wait}, 8'd1);
      m_read(M_DAT, v);
      chk("R9 byte intact", v, 8'h5A);
      chk("R9 error sticky", {7'd0, proto_err}, 8'd1);
   endtask

   task automatic t_slave_reset;
      s_read(4'h2);
      s_read(4'h6);
      m_write(M_CTL, 8'h02);
      s_write(4'h7, 8'h11);
      stat_is("R10 before reset", 8'hE3);
      m_write(M_CTL, 8'h12);
      chk("R10 wait dropped", {7'd0, s_wait}, 8'd0);
      stat_is("R10 flags cleared, master message kept", 8'hCD);
      s_read(4'h2);
      s_write(4'h7, 8'h22);
      chk("R10 data strobe ignored", {7'd0, s_wait}, 8'd0);
      stat_is("R10 strobes ignored", 8'hCD);
      m_write(M_CTL, 8'h00);
      stat_is("R10 released", 8'hED);
   endtask

   task automatic t_collide;
      s_read(4'h3);
      stat_is("R11 setup", 8'hEC);
      @(negedge clk);
      s_io_page = 4'h2; s_rd = 1'b1;
      m_addr = M_CLR; m_wdata = 8'h00; m_wr = 1'b1;
      @(negedge clk); s_rd = 1'b0; m_wr = 1'b0;
      stat_is("R11 slave message set wins", 8'hEE);
      @(negedge clk);
      s_io_page = 4'h3; s_rd = 1'b1;
      m_addr = M_CTL; m_wdata = 8'h02; m_wr = 1'b1;
      @(negedge clk); s_rd = 1'b0; m_wr = 1'b0;
      stat_is("R11 master message set wins", 8'hEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_control();
      t_slave_flags();
      t_master_clear();
      t_slave_write();
      t_slave_read();
      t_protocol();
      t_slave_reset();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule